// File: doc/BRIEF.md
# Linked-Descriptor DMA Engine with Tail Append

This block is a single-channel DMA engine. It follows a chain of descriptors held in a small internal descriptor store and copies 64-bit beats within a model data memory. A host port fills the descriptor store field by field. Each descriptor has five fields: a next-descriptor address, a command bit, a source address, a target address and a byte length. A video buffer is a run of transfer descriptors closed by a terminator entry. The terminator is of one of two kinds. A finisher holds the stop sentinel and has the end-interrupt bit set. A linker has length zero, a clear command bit, and points at the first descriptor of the next buffer.

Software can append a buffer while the engine runs. It does this by rewriting the old tail's finisher into a linker. If the engine has already loaded the stop sentinel, the append is missed. Software detects the miss by reading the exposed next-address (sentinel) and the run flag, and then restarts the engine at the pending buffer's first descriptor.

The engine is a four-state machine. IDLE goes to FETCH on start. FETCH goes to XFER when the length is non-zero, to LINK when the length is zero, and back to IDLE on a bad descriptor. XFER goes to LINK on its last beat. LINK goes to IDLE when the sentinel is loaded, and otherwise back to FETCH.

Top module: `dchain_dma`

## Requirements
- R1: After reset, st_run, st_end and st_err are 0, and st_next is all ones (the sentinel).
- R2: A start pulse in IDLE sets st_run and loads st_next with start_addr, both visible one cycle later. A start pulse while running is ignored.
- R3: A descriptor of length L bytes copies L/8 beats from consecutive 64-bit data words to consecutive data words. The first source word is src>>3 and the first target word is dst>>3. The engine then fetches the descriptor at its next-address. Descriptor entry e lives at byte address e*16.
- R4: A linker (length 0, command bit 0, next = the first descriptor of another buffer) continues the chain into that buffer without stopping.
- R5: Any next-address with bit 0 set is the stop sentinel. When the sentinel has been loaded, the engine halts after the current descriptor. st_end is set only if that descriptor's command bit 0 is 1, and st_next keeps showing the sentinel.
- R6: A descriptor is bad if its length, source or target has any of bits [2:0] set, or if its source or target lies beyond the data memory. A bad descriptor sets st_err, halts the engine, and writes no data.
- R7: st_end and st_err stay set until clr_end or clr_err, respectively, is high for one cycle.
- R8: If the tail finisher is rewritten into a linker before the engine fetches it, the appended buffer is transferred in the same run.
- R9: If the engine has already loaded the sentinel when the rewrite lands, it stops and the new buffer is not transferred. A start at the new buffer's first descriptor then transfers it.
- R10: A descriptor fetch reads all five fields at once. A host write to that entry in the fetch cycle is seen only by later fetches.
- R11: Host descriptor writes use the field codes 0 = next, 1 = command (data bit 0 = end-interrupt enable), 2 = source, 3 = target, 4 = length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dw_en | input | 1 | Descriptor field write enable |
| dw_entry | input | ENT_W | Descriptor entry index |
| dw_field | input | 3 | Field code (R11) |
| dw_data | input | ADDR_W | Field value |
| mw_en | input | 1 | Data memory preload write enable |
| mw_addr | input | DAW | Data word index for preload |
| mw_data | input | BEAT_W | Preload word |
| mr_addr | input | DAW | Data word index for readback |
| mr_data | output | BEAT_W | Readback word |
| start | input | 1 | Start pulse |
| start_addr | input | ADDR_W | First descriptor byte address |
| clr_end | input | 1 | Clear end flag |
| clr_err | input | 1 | Clear error flag |
| st_next | output | ADDR_W | Current next-descriptor address |
| st_run | output | 1 | Engine running |
| st_end | output | 1 | End-interrupt flag |
| st_err | output | 1 | Descriptor error flag |

## Verification
The hardest case to reach from the ports is the missed link. The rewrite of the finisher must land after the engine has fetched the sentinel but before the engine reports that it has stopped. The stimulus polls st_next on every falling edge. As soon as st_next shows the sentinel, it rewrites the finisher, so the write lands while the engine is still in LINK. It then performs the software miss check and restarts the engine. A write that coincides exactly with a fetch (R10) is timed by counting the edges from the start pulse. Random chains of mixed lengths are checked against a word-level model of the copies.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_XFER  = 2'd2,
        ST_LINK  = 2'd3
    } eng_state_t;

    typedef enum logic [2:0] {
        FLD_NEXT = 3'd0,
        FLD_CMD  = 3'd1,
        FLD_SRC  = 3'd2,
        FLD_DST  = 3'd3,
        FLD_LEN  = 3'd4
    } desc_field_t;

    localparam int ENTRY_SHIFT = 4;   // entries are 16-byte aligned
    localparam int BEAT_SHIFT  = 3;   // 8-byte beats
endpackage

// File: rtl/dchain_desc_ram.sv
module dchain_desc_ram
    import dchain_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 16,
    localparam int ENT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ENT_W-1:0]  wr_entry,
    input  logic [2:0]        wr_field,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [ENT_W-1:0]  rd_entry,
    output logic [ADDR_W-1:0] rd_next,
    output logic              rd_cmd,
    output logic [ADDR_W-1:0] rd_src,
    output logic [ADDR_W-1:0] rd_dst,
    output logic [ADDR_W-1:0] rd_len
);
    logic [ADDR_W-1:0] next_m [DEPTH];
    logic              cmd_m  [DEPTH];
    logic [ADDR_W-1:0] src_m  [DEPTH];
    logic [ADDR_W-1:0] dst_m  [DEPTH];
    logic [ADDR_W-1:0] len_m  [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            unique case (desc_field_t'(wr_field))
                FLD_NEXT: next_m[wr_entry] <= wr_data;
                FLD_CMD:  cmd_m[wr_entry]  <= wr_data[0];
                FLD_SRC:  src_m[wr_entry]  <= wr_data;
                FLD_DST:  dst_m[wr_entry]  <= wr_data;
                FLD_LEN:  len_m[wr_entry]  <= wr_data;
                default: ;
            endcase
        end
    end

    // all fields come from one entry in the same cycle
    always_comb begin
        rd_next = next_m[rd_entry];
        rd_cmd  = cmd_m[rd_entry];
        rd_src  = src_m[rd_entry];
        rd_dst  = dst_m[rd_entry];
        rd_len  = len_m[rd_entry];
    end
endmodule

// File: rtl/dchain_data_ram.sv
module dchain_data_ram #(
    parameter int BEAT_W = 64,
    parameter int DEPTH  = 64,
    localparam int DAW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              eng_wr_en,
    input  logic [DAW-1:0]    eng_wr_idx,
    input  logic [BEAT_W-1:0] eng_wr_data,
    input  logic [DAW-1:0]    eng_rd_idx,
    output logic [BEAT_W-1:0] eng_rd_data,
    input  logic              host_wr_en,
    input  logic [DAW-1:0]    host_wr_idx,
    input  logic [BEAT_W-1:0] host_wr_data,
    input  logic [DAW-1:0]    host_rd_idx,
    output logic [BEAT_W-1:0] host_rd_data
);
    logic [BEAT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (eng_wr_en)
            mem[eng_wr_idx] <= eng_wr_data;
        else if (host_wr_en)
            mem[host_wr_idx] <= host_wr_data;
    end

    assign eng_rd_data  = mem[eng_rd_idx];
    assign host_rd_data = mem[host_rd_idx];
endmodule

// File: rtl/dchain_engine.sv
module dchain_engine
    import dchain_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ENT_W  = 4,
    parameter int DAW    = 6,
    parameter int BEAT_W = 64,
    localparam int CNT_W = ADDR_W - BEAT_SHIFT,
    localparam int HI_W  = ADDR_W - BEAT_SHIFT - DAW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              clr_end,
    input  logic              clr_err,
    output logic [ENT_W-1:0]  desc_entry,
    input  logic [ADDR_W-1:0] desc_next,
    input  logic              desc_cmd,
    input  logic [ADDR_W-1:0] desc_src,
    input  logic [ADDR_W-1:0] desc_dst,
    input  logic [ADDR_W-1:0] desc_len,
    output logic [DAW-1:0]    mem_rd_idx,
    input  logic [BEAT_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [DAW-1:0]    mem_wr_idx,
    output logic [BEAT_W-1:0] mem_wr_data,
    output logic [ADDR_W-1:0] st_next,
    output logic              st_run,
    output logic              st_end,
    output logic              st_err
);
    eng_state_t        state_q, state_d;
    logic [ADDR_W-1:0] next_q;
    logic              cmd_q;
    logic [DAW-1:0]    src_q, dst_q;
    logic [CNT_W-1:0]  left_q;
    logic              end_q, err_q;
    logic              desc_bad, len_zero, at_stop, last_beat, set_end, set_err;

    assign desc_entry = next_q[ENTRY_SHIFT +: ENT_W];
    assign at_stop    = next_q[0];
    assign len_zero   = (desc_len[ADDR_W-1:BEAT_SHIFT] == '0);
    assign desc_bad   = (|desc_len[BEAT_SHIFT-1:0]) | (|desc_src[BEAT_SHIFT-1:0])
                      | (|desc_dst[BEAT_SHIFT-1:0])
                      | (desc_src[ADDR_W-1 -: HI_W] != '0)
                      | (desc_dst[ADDR_W-1 -: HI_W] != '0);
    assign last_beat  = (left_q == CNT_W'(1));
    assign set_end    = (state_q == ST_LINK) && at_stop && cmd_q;
    assign set_err    = (state_q == ST_FETCH) && desc_bad;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: begin
                if (desc_bad)      state_d = ST_IDLE;
                else if (len_zero) state_d = ST_LINK;
                else               state_d = ST_XFER;
            end
            ST_XFER:  if (last_beat) state_d = ST_LINK;
            ST_LINK:  state_d = at_stop ? ST_IDLE : ST_FETCH;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '1;
            cmd_q  <= 1'b0;
            src_q  <= '0;
            dst_q  <= '0;
            left_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) next_q <= start_addr;
                ST_FETCH: begin
                    next_q <= desc_next;
                    cmd_q  <= desc_cmd;
                    src_q  <= desc_src[BEAT_SHIFT +: DAW];
                    dst_q  <= desc_dst[BEAT_SHIFT +: DAW];
                    left_q <= desc_len[ADDR_W-1:BEAT_SHIFT];
                end
                ST_XFER: begin
                    src_q  <= src_q + DAW'(1);
                    dst_q  <= dst_q + DAW'(1);
                    left_q <= left_q - CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (set_end)      end_q <= 1'b1;
            else if (clr_end) end_q <= 1'b0;
            if (set_err)      err_q <= 1'b1;
            else if (clr_err) err_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        mem_rd_idx  = src_q;
        mem_wr_idx  = dst_q;
        mem_wr_data = mem_rd_data;
        mem_wr_en   = (state_q == ST_XFER);
        st_next     = next_q;
        st_run      = (state_q != ST_IDLE);
        st_end      = end_q;
        st_err      = err_q;
    end

    // R2: start in idle loads the address and begins a fetch
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (state_q == ST_FETCH && next_q == $past(start_addr)));
    // R5: a loaded sentinel ends the run after LINK
    p_stop_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LINK && at_stop) |=> (state_q == ST_IDLE));
    // R5: end flag rises only from a sentinel with the command bit set
    p_end_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_q) |-> $past(state_q == ST_LINK && next_q[0] && cmd_q));
    // R6: bad descriptor raises the error and stops
    p_bad_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && desc_bad) |=> (state_q == ST_IDLE && err_q && !mem_wr_en));
    // R3: a transfer state always has beats left
    p_beats_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |-> (left_q != '0));
    // R7: end flag holds without a clear
    p_end_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (end_q && !clr_end) |=> end_q);
endmodule

// File: rtl/dchain_dma.sv
module dchain_dma
    import dchain_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DESC_DEPTH = 16,
    parameter int DATA_DEPTH = 64,
    parameter int BEAT_W     = 64,
    localparam int ENT_W     = $clog2(DESC_DEPTH),
    localparam int DAW       = $clog2(DATA_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dw_en,
    input  logic [ENT_W-1:0]  dw_entry,
    input  logic [2:0]        dw_field,
    input  logic [ADDR_W-1:0] dw_data,
    input  logic              mw_en,
    input  logic [DAW-1:0]    mw_addr,
    input  logic [BEAT_W-1:0] mw_data,
    input  logic [DAW-1:0]    mr_addr,
    output logic [BEAT_W-1:0] mr_data,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              clr_end,
    input  logic              clr_err,
    output logic [ADDR_W-1:0] st_next,
    output logic              st_run,
    output logic              st_end,
    output logic              st_err
);
    logic [ENT_W-1:0]  d_entry;
    logic [ADDR_W-1:0] d_next, d_src, d_dst, d_len;
    logic              d_cmd;
    logic [DAW-1:0]    m_rd_idx, m_wr_idx;
    logic [BEAT_W-1:0] m_rd_data, m_wr_data;
    logic              m_wr_en;

    dchain_desc_ram #(.ADDR_W(ADDR_W), .DEPTH(DESC_DEPTH)) u_desc (
        .clk(clk), .wr_en(dw_en), .wr_entry(dw_entry), .wr_field(dw_field),
        .wr_data(dw_data), .rd_entry(d_entry), .rd_next(d_next), .rd_cmd(d_cmd),
        .rd_src(d_src), .rd_dst(d_dst), .rd_len(d_len)
    );

    dchain_data_ram #(.BEAT_W(BEAT_W), .DEPTH(DATA_DEPTH)) u_data (
        .clk(clk), .eng_wr_en(m_wr_en), .eng_wr_idx(m_wr_idx), .eng_wr_data(m_wr_data),
        .eng_rd_idx(m_rd_idx), .eng_rd_data(m_rd_data), .host_wr_en(mw_en),
        .host_wr_idx(mw_addr), .host_wr_data(mw_data), .host_rd_idx(mr_addr),
        .host_rd_data(mr_data)
    );

    dchain_engine #(.ADDR_W(ADDR_W), .ENT_W(ENT_W), .DAW(DAW), .BEAT_W(BEAT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .clr_end(clr_end), .clr_err(clr_err), .desc_entry(d_entry),
        .desc_next(d_next), .desc_cmd(d_cmd), .desc_src(d_src), .desc_dst(d_dst),
        .desc_len(d_len), .mem_rd_idx(m_rd_idx), .mem_rd_data(m_rd_data),
        .mem_wr_en(m_wr_en), .mem_wr_idx(m_wr_idx), .mem_wr_data(m_wr_data),
        .st_next(st_next), .st_run(st_run), .st_end(st_end), .st_err(st_err)
    );
endmodule

// File: tb/dchain_dma_tb.sv
module dchain_dma_tb_top;
    localparam logic [15:0] STOP = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dw_en = 1'b0;
    logic [3:0]  dw_entry = '0;
    logic [2:0]  dw_field = '0;
    logic [15:0] dw_data = '0;
    logic        mw_en = 1'b0;
    logic [5:0]  mw_addr = '0;
    logic [63:0] mw_data = '0;
    logic [5:0]  mr_addr = '0;
    logic [63:0] mr_data;
    logic        start = 1'b0;
    logic [15:0] start_addr = '0;
    logic        clr_end = 1'b0;
    logic        clr_err = 1'b0;
    logic [15:0] st_next;
    logic        st_run, st_end, st_err;

    int nchk = 0;
    int nfail = 0;
    logic [63:0] exp_mem [64];

    always #5 clk = ~clk;

    dchain_dma dut_i (
        .clk(clk), .rst_n(rst_n), .dw_en(dw_en), .dw_entry(dw_entry),
        .dw_field(dw_field), .dw_data(dw_data), .mw_en(mw_en), .mw_addr(mw_addr),
        .mw_data(mw_data), .mr_addr(mr_addr), .mr_data(mr_data), .start(start),
        .start_addr(start_addr), .clr_end(clr_end), .clr_err(clr_err),
        .st_next(st_next), .st_run(st_run), .st_end(st_end), .st_err(st_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic dw(input int e, input int f, input logic [15:0] d);
        dw_en = 1'b1; dw_entry = 4'(e); dw_field = 3'(f); dw_data = d;
        @(posedge clk); @(negedge clk);
        dw_en = 1'b0;
    endtask

    // R11: field codes 0 next, 1 cmd, 2 src, 3 dst, 4 len
    task automatic set_desc(input int e, input logic [15:0] nxt, input logic en,
                            input int sb, input int db, input logic [15:0] len);
        dw(e, 0, nxt);
        dw(e, 1, {15'b0, en});
        dw(e, 2, 16'(sb * 8));
        dw(e, 3, 16'(db * 8));
        dw(e, 4, len);
    endtask

    task automatic go(input logic [15:0] a);
        start = 1'b1; start_addr = a;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_clr(input bit e, input bit r);
        clr_end = e; clr_err = r;
        @(posedge clk); @(negedge clk);
        clr_end = 1'b0; clr_err = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (st_run && n < 5000) begin @(negedge clk); n++; end
        if (n >= 5000) chk(1'b0, "watchdog idle wait", 64'(st_run), 64'd0);
    endtask

    task automatic model_copy(input int s, input int d, input int n);
        for (int k = 0; k < n; k++) exp_mem[d + k] = exp_mem[s + k];
    endtask

    task automatic mem_chk(input string req);
        int bad = 0;
        int first = -1;
        logic [63:0] fa = '0;
        for (int i = 0; i < 64; i++) begin
            mr_addr = 6'(i); #0.1;
            if (mr_data !== exp_mem[i]) begin
                bad++;
                if (first < 0) begin first = i; fa = mr_data; end
            end
        end
        if (bad > 0) chk(1'b0, {req, " data memory"}, fa, exp_mem[first]);
        else         chk(1'b1, req, 64'd0, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [63:0] w;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(st_run == 1'b0, "R1 run", 64'(st_run), 64'd0);
        chk(st_end == 1'b0, "R1 end", 64'(st_end), 64'd0);
        chk(st_err == 1'b0, "R1 err", 64'(st_err), 64'd0);
        chk(st_next == STOP, "R1 next", 64'(st_next), 64'(STOP));
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 64; i++) begin
            w = (i < 32) ? {$urandom, $urandom} : 64'd0;
            exp_mem[i] = w;
            mw_en = 1'b1; mw_addr = 6'(i); mw_data = w;
            @(posedge clk); @(negedge clk);
        end
        mw_en = 1'b0;

        // R2 / R3: one buffer of 4 beats, start ignored while running
        set_desc(0, 16'd16, 1'b0, 0, 32, 16'd32);
        set_desc(1, STOP, 1'b1, 0, 0, 16'd0);
        go(16'd0);
        chk(st_run == 1'b1, "R2 run after start", 64'(st_run), 64'd1);
        chk(st_next == 16'd0, "R2 next after start", 64'(st_next), 64'd0);
        go(16'h0050);
        chk(st_next == 16'd16, "R2 start ignored while running", 64'(st_next), 64'd16);
        wait_idle();
        model_copy(0, 32, 4);
        mem_chk("R3 basic copy");
        chk(st_end == 1'b1, "R5 end after finisher", 64'(st_end), 64'd1);
        chk(st_next == STOP, "R5 next holds sentinel", 64'(st_next), 64'(STOP));
        repeat (5) @(negedge clk);
        chk(st_end == 1'b1, "R7 end sticky", 64'(st_end), 64'd1);
        pulse_clr(1'b1, 1'b0);
        chk(st_end == 1'b0, "R7 end cleared", 64'(st_end), 64'd0);

        // R5: sentinel reached with command bit clear
        set_desc(2, STOP, 1'b0, 4, 40, 16'd16);
        go(16'd32);
        wait_idle();
        model_copy(4, 40, 2);
        mem_chk("R5 copy before plain stop");
        chk(st_end == 1'b0, "R5 no end without enable", 64'(st_end), 64'd0);

        // R4: linker between two buffers
        set_desc(3, 16'd64, 1'b0, 6, 44, 16'd24);
        set_desc(4, 16'd80, 1'b0, 0, 0, 16'd0);
        set_desc(5, 16'd96, 1'b0, 10, 48, 16'd16);
        set_desc(6, STOP, 1'b1, 0, 0, 16'd0);
        go(16'd48);
        wait_idle();
        model_copy(6, 44, 3);
        model_copy(10, 48, 2);
        mem_chk("R4 linker chain");
        chk(st_end == 1'b1, "R4 end at chain tail", 64'(st_end), 64'd1);
        pulse_clr(1'b1, 1'b0);

        // R8: append lands before the finisher is fetched
        set_desc(7, 16'd128, 1'b0, 12, 50, 16'd64);
        set_desc(8, STOP, 1'b1, 0, 0, 16'd0);
        set_desc(9, 16'd160, 1'b0, 20, 58, 16'd24);
        set_desc(10, STOP, 1'b1, 0, 0, 16'd0);
        go(16'd112);
        @(negedge clk);
        dw(8, 0, 16'd144);
        dw(8, 1, 16'd0);
        wait_idle();
        model_copy(12, 50, 8);
        model_copy(20, 58, 3);
        mem_chk("R8 hot append");
        chk(st_end == 1'b1, "R8 end after appended buffer", 64'(st_end), 64'd1);
        pulse_clr(1'b1, 1'b0);

        // R9: append lands after the sentinel was loaded
        set_desc(11, 16'd192, 1'b0, 1, 33, 16'd16);
        set_desc(12, STOP, 1'b1, 0, 0, 16'd0);
        set_desc(13, 16'd224, 1'b0, 2, 36, 16'd16);
        set_desc(14, STOP, 1'b1, 0, 0, 16'd0);
        go(16'd176);
        begin
            int n = 0;
            while (st_next != STOP && n < 100) begin @(negedge clk); n++; end
        end
        chk(st_run == 1'b1, "R9 still running at sentinel", 64'(st_run), 64'd1);
        dw(12, 0, 16'd208);
        dw(12, 1, 16'd0);
        wait_idle();
        model_copy(1, 33, 2);
        mem_chk("R9 missed buffer untouched");
        chk(st_end == 1'b1, "R9 end after miss", 64'(st_end), 64'd1);
        chk(st_next == STOP, "R9 next shows sentinel", 64'(st_next), 64'(STOP));
        pulse_clr(1'b1, 1'b0);
        if (st_next[0] && !st_run) go(16'd208);
        wait_idle();
        model_copy(2, 36, 2);
        mem_chk("R9 restart after miss");
        chk(st_end == 1'b1, "R9 end after restart", 64'(st_end), 64'd1);
        pulse_clr(1'b1, 1'b0);

        // R6: misaligned length, then out-of-range source
        set_desc(15, STOP, 1'b1, 3, 60, 16'd12);
        go(16'd240);
        wait_idle();
        chk(st_err == 1'b1, "R6 misaligned length", 64'(st_err), 64'd1);
        chk(st_end == 1'b0, "R6 no end on error", 64'(st_end), 64'd0);
        mem_chk("R6 no data written");
        pulse_clr(1'b0, 1'b1);
        chk(st_err == 1'b0, "R7 err cleared", 64'(st_err), 64'd0);
        dw(15, 4, 16'd8);
        dw(15, 2, 16'h8000);
        go(16'd240);
        wait_idle();
        chk(st_err == 1'b1, "R6 source out of range", 64'(st_err), 64'd1);
        mem_chk("R6 no data on range error");
        pulse_clr(1'b0, 1'b1);

        // R10: write in the fetch cycle is seen only later
        set_desc(2, STOP, 1'b0, 5, 52, 16'd8);
        start = 1'b1; start_addr = 16'd32;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        dw(2, 4, 16'd24);
        wait_idle();
        model_copy(5, 52, 1);
        mem_chk("R10 fetch used old length");
        go(16'd32);
        wait_idle();
        model_copy(5, 52, 3);
        mem_chk("R10 later fetch uses new length");

        // R3 / R5: random chains
        for (int it = 0; it < 20; it++) begin
            int nd = 1 + int'($urandom % 3);
            logic en = 1'($urandom % 2);
            for (int i = 0; i < nd; i++) begin
                int n = 1 + int'($urandom % 4);
                int s = int'($urandom % (32 - n));
                int d = 32 + int'($urandom % (32 - n));
                set_desc(i, 16'((i + 1) * 16), 1'b0, s, d, 16'(n * 8));
                model_copy(s, d, n);
            end
            set_desc(nd, STOP, en, 0, 0, 16'd0);
            go(16'd0);
            wait_idle();
            mem_chk("R3 random chain");
            chk(st_end == en, "R5 random end flag", 64'(st_end), 64'(en));
            pulse_clr(1'b1, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule